// File: doc/BRIEF.md
# Indexed Display-Mode Register File

This block is the register file of a plain linear-framebuffer display adapter. It stores the geometry and format of the current display mode and presents that mode, already decoded, to a scan-out engine. Software reaches the same storage in two ways. The first is an I/O port pair: it writes a register number to the index port, then moves 16-bit data through the data port. The second is a flat memory-mapped window in which every register has its own halfword address. Two 32-bit extension words sit next to that window. One reports the size of the extension area. The other selects the framebuffer byte order.

The mode registers feed the scan-out outputs directly only while the display is off. Once the display-enable bit is live, writes to geometry registers change the stored copy and its read-back, but the outputs hold. A write to the enable register copies the whole stored set to the outputs at once, so the scan-out engine never sees a mode that is only partly programmed. A capability-report flag makes the resolution and depth registers read back their maximum values instead of the stored ones.

Accesses are single-cycle strobes. A read returns its data, flagged valid, on the clock edge after the strobe. Every mode output is registered.

Top module: `dispmode_regs`

## Requirements
- R1: A write to I/O port 0x01CE stores a 16-bit register number. A read of that port returns it. The number stays unchanged through any number of data-port accesses, so repeated reads or writes of port 0x01CF all reach the same register.
- R2: Port 0x01CF reads and writes the register selected by R1. Registers 1 (X resolution), 2 (Y resolution), 3 (depth), 5 (bank), 6 (virtual width), 7 (virtual height), 8 (X pan) and 9 (Y pan) keep all 16 written bits.
- R3: In the memory window, the halfword at byte address 0x500 + 2·n is register n. A value written through either path reads back identically through the other.
- R4: Register 0 reads the identity value (default 0xB0C5, top twelve bits 0xB0C). Register 10 reads the memory size in 64 KiB units (default 0x0100). Writes to both are ignored.
- R5: The following read 0, and writes to them change nothing:
  - register numbers 11 to 65535;
  - odd window addresses;
  - window slots 11 to 15;
  - any I/O port other than the pair;
  - any other memory address.
- R6: Register 4 (enable) keeps only bit 0 (display on), bit 1 (report capabilities), bit 5 (8-bit DAC), bit 6 (linear framebuffer) and bit 7 (keep memory). Its other bits read 0.
- R7: While the display-on bit of `out_flags` is 0, a register write shows on the matching mode output one cycle after the access.
- R8: While the display-on bit of `out_flags` is 1, writes to registers other than register 4 change the read-back but not the mode outputs. The next write to register 4 loads every mode output from the stored registers.
- R9: While stored bit 1 of register 4 is set, registers 1, 2 and 3 read back MAX_X (default 2560), MAX_Y (default 1600) and MAX_BPP (default 32). Their stored values are not lost and read back again once the bit is cleared.
- R10: Memory address 0x600 reads EXT_SIZE (default 8). The word at 0x604 accepts only 0xBEBEBEBE (big-endian, `out_big_endian` = 1) or 0x1E1E1E1E (little-endian, `out_big_endian` = 0). Other values are ignored. The reset value is little-endian.
- R11: After reset, all stored registers, the index and all mode outputs are 0. A read raises `rd_valid` with its data one cycle after the access. A write never raises `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_mmio | input | 1 | 1 = memory window address, 0 = I/O port address |
| acc_addr | input | 16 | Port number or window byte address |
| acc_wdata | input | 32 | Write data; registers use bits 15:0 |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| out_xres | output | 16 | Live X resolution |
| out_yres | output | 16 | Live Y resolution |
| out_bpp | output | 16 | Live bits per pixel |
| out_flags | output | 8 | Live enable flags |
| out_bank | output | 16 | Live bank |
| out_vwidth | output | 16 | Live virtual width |
| out_vheight | output | 16 | Live virtual height |
| out_xoff | output | 16 | Live X pan offset |
| out_yoff | output | 16 | Live Y pan offset |
| out_big_endian | output | 1 | Framebuffer byte order, 1 = big-endian |

## Verification
A stale or corrupted index shows up on the very next data-port access: it returns a different register's value, and reading the index port back exposes it directly. A broken address decode shows as one path failing to read back what the other wrote, which a sweep over every register catches within two accesses. If the commit logic is wrong, a mode output either moves on the cycle after a geometry write while the display is on, or stays stale after the write to register 4. Both are visible one clock after the offending access.

// File: rtl/dm_pkg.sv
package dm_pkg;

  localparam int NREG  = 11;
  localparam int REG_W = 16;

  localparam int RI_ID     = 0;
  localparam int RI_XRES   = 1;
  localparam int RI_YRES   = 2;
  localparam int RI_BPP    = 3;
  localparam int RI_ENABLE = 4;
  localparam int RI_BANK   = 5;
  localparam int RI_VWIDTH = 6;
  localparam int RI_VHEIGHT= 7;
  localparam int RI_XOFF   = 8;
  localparam int RI_YOFF   = 9;
  localparam int RI_VMEM   = 10;

  localparam logic [15:0] IO_INDEX_PORT = 16'h01CE;
  localparam logic [15:0] IO_DATA_PORT  = 16'h01CF;
  localparam logic [15:0] WIN_BASE      = 16'h0500;
  localparam logic [15:0] EXT_SIZE_ADDR = 16'h0600;
  localparam logic [15:0] ENDIAN_ADDR   = 16'h0604;

  localparam logic [REG_W-1:0] FLAG_MASK = 16'h00E3;
  localparam int FLAG_ON   = 0;
  localparam int FLAG_CAPS = 1;

  localparam logic [31:0] ORDER_BIG    = 32'hBEBEBEBE;
  localparam logic [31:0] ORDER_LITTLE = 32'h1E1E1E1E;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_INDEX,
    TGT_REG,
    TGT_EXTSZ,
    TGT_ORDER
  } tgt_e;

  typedef struct packed {
    logic [REG_W-1:0] xres;
    logic [REG_W-1:0] yres;
    logic [REG_W-1:0] bpp;
    logic [7:0]       flags;
    logic [REG_W-1:0] bank;
    logic [REG_W-1:0] vwidth;
    logic [REG_W-1:0] vheight;
    logic [REG_W-1:0] xoff;
    logic [REG_W-1:0] yoff;
  } mode_t;

  typedef logic [NREG-1:0][REG_W-1:0] regset_t;

  function automatic logic reg_writable(input int n);
    return (n >= RI_XRES) && (n <= RI_YOFF);
  endfunction

  function automatic logic [REG_W-1:0] field_mask(input int n);
    return (n == RI_ENABLE) ? FLAG_MASK : {REG_W{1'b1}};
  endfunction

  function automatic logic [15:0] window_slot(input logic [15:0] addr);
    logic [15:0] rel;
    rel = addr - WIN_BASE;
    return {1'b0, rel[15:1]};
  endfunction

  function automatic mode_t pack_mode(input regset_t s);
    mode_t m;
    m.xres    = s[RI_XRES];
    m.yres    = s[RI_YRES];
    m.bpp     = s[RI_BPP];
    m.flags   = s[RI_ENABLE][7:0];
    m.bank    = s[RI_BANK];
    m.vwidth  = s[RI_VWIDTH];
    m.vheight = s[RI_VHEIGHT];
    m.xoff    = s[RI_XOFF];
    m.yoff    = s[RI_YOFF];
    return m;
  endfunction

endpackage

// File: rtl/dm_decode.sv
module dm_decode
  import dm_pkg::*;
#(
  parameter int WIN_SLOTS = 16
) (
  input  logic        acc_mmio,
  input  logic [15:0] acc_addr,
  input  logic [15:0] index_q,
  output tgt_e        tgt,
  output logic [15:0] reg_num
);

  localparam logic [15:0] WIN_END = WIN_BASE + 16'(2 * WIN_SLOTS);

  always_comb begin
    tgt     = TGT_NONE;
    reg_num = '0;
    if (!acc_mmio) begin
      if (acc_addr == IO_INDEX_PORT) begin
        tgt = TGT_INDEX;
      end else if (acc_addr == IO_DATA_PORT) begin
        tgt     = TGT_REG;
        reg_num = index_q;
      end
    end else begin
      if (acc_addr >= WIN_BASE && acc_addr < WIN_END && !acc_addr[0]) begin
        tgt     = TGT_REG;
        reg_num = window_slot(acc_addr);
      end else if (acc_addr == EXT_SIZE_ADDR) begin
        tgt = TGT_EXTSZ;
      end else if (acc_addr == ENDIAN_ADDR) begin
        tgt = TGT_ORDER;
      end
    end
  end

endmodule

// File: rtl/dm_regstore.sv
module dm_regstore
  import dm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [31:0] acc_wdata,
  input  tgt_e        tgt,
  input  logic [15:0] reg_num,
  output logic [15:0] index_q,
  output regset_t     shadow_q,
  output logic [31:0] order_q,
  output mode_t       live_q,
  output logic        idx_wr_evt,
  output logic        reg_wr_evt,
  output logic        commit_evt,
  output logic        order_wr_evt
);

  logic    wr;
  logic    in_range;
  logic    live_upd;
  regset_t shadow_nx;

  assign wr         = acc_valid && acc_write;
  assign in_range   = reg_num < 16'(NREG);
  assign idx_wr_evt = wr && (tgt == TGT_INDEX);
  assign reg_wr_evt = wr && (tgt == TGT_REG) && in_range && reg_writable(int'(reg_num));
  assign commit_evt = reg_wr_evt && (reg_num == 16'(RI_ENABLE));
  assign order_wr_evt = wr && (tgt == TGT_ORDER) &&
                        (acc_wdata == ORDER_BIG || acc_wdata == ORDER_LITTLE);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (reg_writable(g)) begin : g_store
      assign shadow_nx[g] = (reg_wr_evt && reg_num == 16'(g))
                          ? (acc_wdata[REG_W-1:0] & field_mask(g))
                          : shadow_q[g];
      always_ff @(posedge clk) begin
        if (!rst_n) shadow_q[g] <= '0;
        else        shadow_q[g] <= shadow_nx[g];
      end
    end else begin : g_const
      assign shadow_nx[g] = '0;
      assign shadow_q[g]  = '0;
    end
  end

  assign live_upd = commit_evt || !live_q.flags[FLAG_ON];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= '0;
      order_q <= ORDER_LITTLE;
      live_q  <= '0;
    end else begin
      if (idx_wr_evt)   index_q <= acc_wdata[15:0];
      if (order_wr_evt) order_q <= acc_wdata;
      if (live_upd)     live_q  <= pack_mode(shadow_nx);
    end
  end

endmodule

// File: rtl/dm_readmux.sv
module dm_readmux
  import dm_pkg::*;
#(
  parameter logic [15:0] ID_VALUE = 16'hB0C5,
  parameter logic [15:0] VMEM_64K = 16'h0100,
  parameter logic [15:0] MAX_X    = 16'd2560,
  parameter logic [15:0] MAX_Y    = 16'd1600,
  parameter logic [15:0] MAX_BPP  = 16'd32,
  parameter logic [31:0] EXT_SIZE = 32'd8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  tgt_e        tgt,
  input  logic [15:0] reg_num,
  input  logic [15:0] index_q,
  input  regset_t     shadow_q,
  input  logic [31:0] order_q,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        unimpl_rd_evt
);

  logic        rd_evt;
  logic        caps;
  logic        in_range;
  logic [31:0] rd_val;

  assign rd_evt   = acc_valid && !acc_write;
  assign caps     = shadow_q[RI_ENABLE][FLAG_CAPS];
  assign in_range = reg_num < 16'(NREG);
  assign unimpl_rd_evt = rd_evt && ((tgt == TGT_NONE) || (tgt == TGT_REG && !in_range));

  function automatic logic [15:0] reg_value(input logic [15:0] n, input regset_t s,
                                            input logic cap_on);
    logic [15:0] v;
    case (int'(n))
      RI_ID:   v = ID_VALUE;
      RI_VMEM: v = VMEM_64K;
      RI_XRES: v = cap_on ? MAX_X   : s[RI_XRES];
      RI_YRES: v = cap_on ? MAX_Y   : s[RI_YRES];
      RI_BPP:  v = cap_on ? MAX_BPP : s[RI_BPP];
      default: v = (n < 16'(NREG)) ? s[n[3:0]] : 16'h0000;
    endcase
    return v;
  endfunction

  always_comb begin
    case (tgt)
      TGT_INDEX: rd_val = {16'h0000, index_q};
      TGT_REG:   rd_val = {16'h0000, reg_value(reg_num, shadow_q, caps)};
      TGT_EXTSZ: rd_val = EXT_SIZE;
      TGT_ORDER: rd_val = order_q;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_evt;
      if (rd_evt) rd_data <= rd_val;
    end
  end

endmodule

// File: rtl/dispmode_regs.sv
module dispmode_regs
  import dm_pkg::*;
#(
  parameter logic [15:0] ID_VALUE  = 16'hB0C5,
  parameter logic [15:0] VMEM_64K  = 16'h0100,
  parameter logic [15:0] MAX_X     = 16'd2560,
  parameter logic [15:0] MAX_Y     = 16'd1600,
  parameter logic [15:0] MAX_BPP   = 16'd32,
  parameter logic [31:0] EXT_SIZE  = 32'd8,
  parameter int          WIN_SLOTS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic        acc_mmio,
  input  logic [15:0] acc_addr,
  input  logic [31:0] acc_wdata,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic [15:0] out_xres,
  output logic [15:0] out_yres,
  output logic [15:0] out_bpp,
  output logic [7:0]  out_flags,
  output logic [15:0] out_bank,
  output logic [15:0] out_vwidth,
  output logic [15:0] out_vheight,
  output logic [15:0] out_xoff,
  output logic [15:0] out_yoff,
  output logic        out_big_endian
);

  tgt_e        tgt;
  logic [15:0] reg_num;
  logic [15:0] index_q;
  regset_t     shadow_q;
  logic [31:0] order_q;
  mode_t       live_q;
  logic        idx_wr_evt;
  logic        reg_wr_evt;
  logic        commit_evt;
  logic        order_wr_evt;
  logic        unimpl_rd_evt;

  dm_decode #(.WIN_SLOTS(WIN_SLOTS)) u_dec (
    .acc_mmio (acc_mmio),
    .acc_addr (acc_addr),
    .index_q  (index_q),
    .tgt      (tgt),
    .reg_num  (reg_num)
  );

  dm_regstore u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_wdata    (acc_wdata),
    .tgt          (tgt),
    .reg_num      (reg_num),
    .index_q      (index_q),
    .shadow_q     (shadow_q),
    .order_q      (order_q),
    .live_q       (live_q),
    .idx_wr_evt   (idx_wr_evt),
    .reg_wr_evt   (reg_wr_evt),
    .commit_evt   (commit_evt),
    .order_wr_evt (order_wr_evt)
  );

  dm_readmux #(
    .ID_VALUE (ID_VALUE),
    .VMEM_64K (VMEM_64K),
    .MAX_X    (MAX_X),
    .MAX_Y    (MAX_Y),
    .MAX_BPP  (MAX_BPP),
    .EXT_SIZE (EXT_SIZE)
  ) u_rd (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .tgt           (tgt),
    .reg_num       (reg_num),
    .index_q       (index_q),
    .shadow_q      (shadow_q),
    .order_q       (order_q),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data),
    .unimpl_rd_evt (unimpl_rd_evt)
  );

  assign out_xres       = live_q.xres;
  assign out_yres       = live_q.yres;
  assign out_bpp        = live_q.bpp;
  assign out_flags      = live_q.flags;
  assign out_bank       = live_q.bank;
  assign out_vwidth     = live_q.vwidth;
  assign out_vheight    = live_q.vheight;
  assign out_xoff       = live_q.xoff;
  assign out_yoff       = live_q.yoff;
  assign out_big_endian = (order_q == ORDER_BIG);

endmodule

// File: rtl/dm_chk.sv
module dm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [31:0] acc_wdata,
  input logic        rd_valid,
  input logic [31:0] rd_data,
  input logic [15:0] out_xres,
  input logic [15:0] out_yres,
  input logic [15:0] out_bpp,
  input logic [7:0]  out_flags,
  input logic [15:0] out_bank,
  input logic [15:0] out_vwidth,
  input logic [15:0] out_vheight,
  input logic [15:0] out_xoff,
  input logic [15:0] out_yoff,
  input logic        out_big_endian,
  input logic [15:0] index_q,
  input logic [15:0] reg_num,
  input logic        idx_wr_evt,
  input logic        reg_wr_evt,
  input logic        commit_evt,
  input logic        order_wr_evt,
  input logic        unimpl_rd_evt
);

  // R1
  index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr_evt |=> $stable(index_q));

  // R7
  follow_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_flags[0] && reg_wr_evt && reg_num == 16'd1) |=> out_xres == $past(acc_wdata[15:0]));

  // R8
  hold_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_flags[0] && !commit_evt) |=>
      $stable({out_xres, out_yres, out_bpp, out_flags, out_bank,
               out_vwidth, out_vheight, out_xoff, out_yoff}));

  // R5
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl_rd_evt |=> rd_data == 32'h0);

  // R10
  order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !order_wr_evt |=> $stable(out_big_endian));

  // R10
  order_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    order_wr_evt |=> out_big_endian == $past(acc_wdata == 32'hBEBEBEBE));

  // R11
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid);

  // R11
  no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> !rd_valid);

endmodule

bind dispmode_regs dm_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .acc_valid      (acc_valid),
  .acc_write      (acc_write),
  .acc_wdata      (acc_wdata),
  .rd_valid       (rd_valid),
  .rd_data        (rd_data),
  .out_xres       (out_xres),
  .out_yres       (out_yres),
  .out_bpp        (out_bpp),
  .out_flags      (out_flags),
  .out_bank       (out_bank),
  .out_vwidth     (out_vwidth),
  .out_vheight    (out_vheight),
  .out_xoff       (out_xoff),
  .out_yoff       (out_yoff),
  .out_big_endian (out_big_endian),
  .index_q        (index_q),
  .reg_num        (reg_num),
  .idx_wr_evt     (idx_wr_evt),
  .reg_wr_evt     (reg_wr_evt),
  .commit_evt     (commit_evt),
  .order_wr_evt   (order_wr_evt),
  .unimpl_rd_evt  (unimpl_rd_evt)
);

// File: tb/sim_dispmode_regs.sv
`timescale 1ns/1ps
module sim_dispmode_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic        acc_mmio = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [15:0] out_xres, out_yres, out_bpp, out_bank, out_vwidth, out_vheight, out_xoff, out_yoff;
  logic [7:0]  out_flags;
  logic        out_big_endian;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [15:0] model [0:15];

  always #5 clk = ~clk;

  dispmode_regs u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_mmio(acc_mmio), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .out_xres(out_xres), .out_yres(out_yres), .out_bpp(out_bpp), .out_flags(out_flags),
    .out_bank(out_bank), .out_vwidth(out_vwidth), .out_vheight(out_vheight),
    .out_xoff(out_xoff), .out_yoff(out_yoff), .out_big_endian(out_big_endian)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit mmio, input bit wr, input logic [15:0] a,
                     input logic [31:0] d, output logic [31:0] rd, output logic rv);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_mmio = mmio; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    rv = rd_valid; rd = rd_data;
  endtask

  task automatic wr(input bit mmio, input logic [15:0] a, input logic [31:0] d);
    logic [31:0] r; logic v;
    acc(mmio, 1'b1, a, d, r, v);
    chk("R11 write gives no rd_valid", {31'd0, v}, 32'd0);
  endtask

  task automatic rd(input bit mmio, input logic [15:0] a, output logic [31:0] r);
    logic v;
    acc(mmio, 1'b0, a, 32'd0, r, v);
    chk("R11 read gives rd_valid", {31'd0, v}, 32'd1);
  endtask

  function automatic logic [15:0] win(input int n);
    return 16'h0500 + 16'(2 * n);
  endfunction

  function automatic logic [15:0] out_of(input int n);
    case (n)
      1: return out_xres;
      2: return out_yres;
      3: return out_bpp;
      4: return {8'h00, out_flags};
      5: return out_bank;
      6: return out_vwidth;
      7: return out_vheight;
      8: return out_xoff;
      default: return out_yoff;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, r2;
    logic [15:0] v;
    for (int i = 0; i < 16; i++) model[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    for (int n = 1; n <= 9; n++) chk("R11 output zero after reset", {16'h0, out_of(n)}, 32'h0);
    chk("R11 byte order little after reset", {31'd0, out_big_endian}, 32'd0);
    rd(1'b0, 16'h01CE, r); chk("R11 index zero after reset", r, 32'h0);

    // R4 identity and memory size
    wr(1'b0, 16'h01CE, 32'd0);
    rd(1'b0, 16'h01CF, r); chk("R4 id via port", r, 32'h0000B0C5);
    chk("R4 id top bits", {20'd0, r[15:4]}, 32'h00000B0C);
    wr(1'b1, win(0), 32'h1234);
    rd(1'b1, win(0), r); chk("R4 id write ignored", r, 32'h0000B0C5);
    wr(1'b1, win(10), 32'h7777);
    rd(1'b1, win(10), r); chk("R4 memory size", r, 32'h00000100);

    // R2 R3 R7 sweep: port write / window read, then window write / port read
    for (int n = 1; n <= 9; n++) begin
      if (n == 4) continue;
      v = 16'(n * 16'h1111) ^ 16'h5A00;
      wr(1'b0, 16'h01CE, 32'(n));
      wr(1'b0, 16'h01CF, {16'hFFFF, v});
      model[n] = v;
      rd(1'b1, win(n), r); chk("R3 port write seen in window", r, {16'h0, v});
      chk("R7 output follows while off", {16'h0, out_of(n)}, {16'h0, v});
      v = ~v;
      wr(1'b1, win(n), {16'h0, v});
      model[n] = v;
      rd(1'b0, 16'h01CF, r); chk("R2 window write seen at port", r, {16'h0, v});
    end

    // R1 index persistence
    wr(1'b0, 16'h01CE, 32'd6);
    rd(1'b0, 16'h01CE, r); chk("R1 index readback", r, 32'd6);
    rd(1'b0, 16'h01CF, r); rd(1'b0, 16'h01CF, r2);
    chk("R1 repeated read first", r, {16'h0, model[6]});
    chk("R1 repeated read second", r2, {16'h0, model[6]});
    wr(1'b0, 16'h01CF, 32'h0ABC); model[6] = 16'h0ABC;
    rd(1'b0, 16'h01CF, r); chk("R1 write then read same reg", r, 32'h0ABC);
    rd(1'b0, 16'h01CE, r); chk("R1 index unchanged by data access", r, 32'd6);

    // R5 unimplemented space
    for (int k = 11; k <= 15; k++) begin
      wr(1'b0, 16'h01CE, 32'(k));
      wr(1'b0, 16'h01CF, 32'hFFFF);
      rd(1'b0, 16'h01CF, r); chk("R5 unimplemented number reads 0", r, 32'h0);
      rd(1'b1, win(k), r); chk("R5 unused window slot reads 0", r, 32'h0);
    end
    wr(1'b0, 16'h01CE, 32'h8005);
    rd(1'b0, 16'h01CF, r); chk("R5 large number reads 0", r, 32'h0);
    rd(1'b1, 16'h0503, r); chk("R5 odd window address reads 0", r, 32'h0);
    wr(1'b1, 16'h0503, 32'hFFFF);
    rd(1'b1, win(1), r); chk("R5 odd write leaves reg 1", r, {16'h0, model[1]});
    rd(1'b0, 16'h03C0, r); chk("R5 other port reads 0", r, 32'h0);
    rd(1'b1, 16'h0700, r); chk("R5 other address reads 0", r, 32'h0);

    // R6 enable masking (bit 0 kept clear so display stays off)
    wr(1'b1, win(4), 32'hFFFC);
    rd(1'b1, win(4), r); chk("R6 enable keeps bits 7,6,5", r, 32'h00E0);
    chk("R7 flags follow while off", {24'h0, out_flags}, 32'hE0);
    wr(1'b1, win(4), 32'h0);

    // R9 capability report
    wr(1'b1, win(4), 32'h0002);
    rd(1'b1, win(1), r); chk("R9 caps max x", r, 32'd2560);
    rd(1'b1, win(2), r); chk("R9 caps max y", r, 32'd1600);
    rd(1'b1, win(3), r); chk("R9 caps max bpp", r, 32'd32);
    rd(1'b1, win(5), r); chk("R9 caps leaves bank", r, {16'h0, model[5]});
    wr(1'b1, win(4), 32'h0);
    rd(1'b1, win(1), r); chk("R9 stored x returns", r, {16'h0, model[1]});

    // R8 commit semantics
    wr(1'b1, win(4), 32'h0041);
    chk("R8 enable commits flags", {24'h0, out_flags}, 32'h41);
    chk("R8 enable commits xres", {16'h0, out_xres}, {16'h0, model[1]});
    wr(1'b1, win(1), 32'h0320);
    wr(1'b0, 16'h01CE, 32'd9);
    wr(1'b0, 16'h01CF, 32'h0044);
    rd(1'b1, win(1), r); chk("R8 readback updated while on", r, 32'h0320);
    chk("R8 xres output held while on", {16'h0, out_xres}, {16'h0, model[1]});
    chk("R8 yoff output held while on", {16'h0, out_yoff}, {16'h0, model[9]});
    wr(1'b1, win(4), 32'h0041);
    chk("R8 xres after commit", {16'h0, out_xres}, 32'h0320);
    chk("R8 yoff after commit", {16'h0, out_yoff}, 32'h0044);
    wr(1'b1, win(4), 32'h0);
    chk("R8 disable commits flags", {24'h0, out_flags}, 32'h0);

    // R10 extension words
    rd(1'b1, 16'h0600, r); chk("R10 extension size", r, 32'd8);
    rd(1'b1, 16'h0604, r); chk("R10 order reset value", r, 32'h1E1E1E1E);
    wr(1'b1, 16'h0604, 32'hBEBEBEBE);
    chk("R10 big order output", {31'd0, out_big_endian}, 32'd1);
    wr(1'b1, 16'h0604, 32'h12345678);
    rd(1'b1, 16'h0604, r); chk("R10 bad order value ignored", r, 32'hBEBEBEBE);
    chk("R10 output held on bad value", {31'd0, out_big_endian}, 32'd1);
    wr(1'b1, 16'h0604, 32'h1E1E1E1E);
    chk("R10 little order output", {31'd0, out_big_endian}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule